// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block is an 8-pin general-purpose I/O port that a processor controls over a simple register bus. A direction register decides which pins drive. An output latch holds the value driven on them. The port register returns the levels actually seen on the pins, after a two-stage synchronizer. The latch can be written through two addresses: the port address and the latch address. Only the latch address reads the latch back, so read-modify-write sequences are done on the latch address.

Two inputs take pins away from digital use. A five-bit analog-select register can claim pins 0 to 3 and pin 5. A claimed pin reads as zero in the port register, but its driver is still governed by its direction bit. A strap input, `osc_mode`, hands pins 6 and 7 to an oscillator. While it is high, those bits read as zero in the port, latch and direction registers, and their output enables are held low. The stored direction and latch bits are kept and are visible again once the strap is released.

Top module: `gpio_port8`

## Requirements
- R1: A direction bit of 1 makes its pin an input (`pin_oe` bit low). A direction bit of 0 sets `pin_oe` high. `pin_out` always presents the output latch.
- R2: Reading address 0 (port) returns the pin levels through a two-flop synchronizer. A pin change made between two clock edges appears on `bus_rdata` after the second rising edge.
- R3: A write to address 0 loads the output latch, but a read of address 0 keeps returning pin levels, not the latch.
- R4: A write to address 1 (latch) loads the same latch. A read of address 1 returns the latch, whatever the pin levels or the direction.
- R5: While `osc_mode` is 1, bits 7:6 read as 0 at addresses 0, 1 and 2, and `pin_oe[7:6]` is 0 whatever the direction bits hold. The stored bits are preserved and reappear when `osc_mode` returns to 0.
- R6: Address 3 holds the analog-select bits in `bus_rdata[4:0]`. Bits 3:0 claim pins 3:0 and bit 4 claims pin 5. Bits 7:5 read as 0 and ignore writes. A claimed pin reads as 0 at address 0.
- R7: An analog-claimed pin keeps its output enable under the control of its direction bit.
- R8: Reset (asynchronous, active low) gives direction 8'hFF, latch 8'h00 and analog select 5'h1F. Out of reset, address 0 therefore shows only pins 4, 6 and 7.
- R9: Addresses 4 to 7 read as 0, and writes to them change no register.
- R10: A write takes effect on the rising clock edge only when `bus_we` is 1. Read data follows `bus_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 3 | Register select: 0 port, 1 latch, 2 direction, 3 analog select |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| osc_mode | input | 1 | Strap: 1 hands pins 7:6 to the oscillator |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output-driver enable |
| pin_out | output | 8 | Per-pin output data |

## Verification
The stimulus writes the latch through both of its addresses while holding pin levels that differ from the latch value. A register that returns the wrong source, pins instead of latch or the reverse, therefore shows up at once. Each read is repeated with analog select all set, all clear and mixed, and with the strap high and low. This separates masking at the port address from masking of the direction and latch addresses, and masking of the read value from masking of the output enables. Directed steps time a pin edge against the synchronizer one edge at a time. They also confirm that unused addresses leave the registers alone, and that an asynchronous reset in the middle of a run restores the reset values.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int PIN_W = 8;
  localparam int ANA_W = 5;

  // Register selects; the bus decode depends on these values.
  typedef enum logic [2:0] {
    SEL_PORT  = 3'd0,
    SEL_LATCH = 3'd1,
    SEL_DIR   = 3'd2,
    SEL_ANA   = 3'd3
  } reg_sel_e;

  // Pins that the oscillator strap claims.
  localparam logic [PIN_W-1:0] OSC_PIN_MASK = 8'hC0;

  // Spread the analog-select bits onto pin positions 3:0 and 5.
  function automatic logic [PIN_W-1:0] ana_pin_mask(input logic [ANA_W-1:0] sel);
    return {2'b00, sel[4], 1'b0, sel[3:0]};
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = async_in;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= '0;
        end else begin
          stage_q[g] <= stage_d[g];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PIN_W-1:0]  wr_data,
  output logic [PIN_W-1:0]  lat_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [ANA_W-1:0]  ana_q
);

  logic             lat_en;
  logic             dir_en;
  logic             ana_en;
  logic [PIN_W-1:0] lat_d;
  logic [PIN_W-1:0] dir_d;
  logic [ANA_W-1:0] ana_d;

  // Next-state decode: the port and latch addresses share one latch.
  always_comb begin
    lat_en = wr_en && ((wr_addr == ADDR_W'(SEL_PORT)) || (wr_addr == ADDR_W'(SEL_LATCH)));
    dir_en = wr_en && (wr_addr == ADDR_W'(SEL_DIR));
    ana_en = wr_en && (wr_addr == ADDR_W'(SEL_ANA));
    lat_d  = wr_data;
    dir_d  = wr_data;
    ana_d  = wr_data[ANA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
      ana_q <= '1;
    end else begin
      if (lat_en) lat_q <= lat_d;
      if (dir_en) dir_q <= dir_d;
      if (ana_en) ana_q <= ana_d;
    end
  end

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [PIN_W-1:0]  pins_sync,
  input  logic [PIN_W-1:0]  lat_q,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [ANA_W-1:0]  ana_q,
  input  logic [PIN_W-1:0]  osc_mask,
  output logic [PIN_W-1:0]  rd_data
);

  logic [PIN_W-1:0] port_keep;
  logic [PIN_W-1:0] reg_keep;

  always_comb begin
    port_keep = ~(ana_pin_mask(ana_q) | osc_mask);
    reg_keep  = ~osc_mask;
    rd_data   = '0;
    if (rd_addr == ADDR_W'(SEL_PORT)) begin
      rd_data = pins_sync & port_keep;
    end else if (rd_addr == ADDR_W'(SEL_LATCH)) begin
      rd_data = lat_q & reg_keep;
    end else if (rd_addr == ADDR_W'(SEL_DIR)) begin
      rd_data = dir_q & reg_keep;
    end else if (rd_addr == ADDR_W'(SEL_ANA)) begin
      rd_data = {{(PIN_W-ANA_W){1'b0}}, ana_q};
    end
  end

endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic              osc_mode,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_oe,
  output logic [PIN_W-1:0]  pin_out
);

  logic             rst_sync_n;
  logic [PIN_W-1:0] pins_sync;
  logic [PIN_W-1:0] lat_q;
  logic [PIN_W-1:0] dir_q;
  logic [ANA_W-1:0] ana_q;
  logic [PIN_W-1:0] osc_mask;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .lat_q   (lat_q),
    .dir_q   (dir_q),
    .ana_q   (ana_q)
  );

  assign osc_mask = osc_mode ? OSC_PIN_MASK : '0;

  gpio_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .rd_addr   (bus_addr),
    .pins_sync (pins_sync),
    .lat_q     (lat_q),
    .dir_q     (dir_q),
    .ana_q     (ana_q),
    .osc_mask  (osc_mask),
    .rd_data   (bus_rdata)
  );

  // Drivers follow direction even on analog pins; the strap overrides pins 7:6.
  assign pin_oe  = ~dir_q & ~osc_mask;
  assign pin_out = lat_q;

endmodule

// File: rtl/gpio_port8_chk.sv
module gpio_port8_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              osc_mode,
  input logic [7:0]        pin_oe,
  input logic [7:0]        pin_out
);

  // R1, R7: a direction write sets the low six enables on the next cycle.
  assert_dir_sets_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(2)) |=> (pin_oe[5:0] == ~$past(bus_wdata[5:0])));

  // R3, R4: both latch addresses load the driven value.
  assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1))) |=> (pin_out == $past(bus_wdata)));

  // R10: without a latch write the driven value holds.
  assert_out_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1))) |=> $stable(pin_out));

  // R5: strap keeps pins 7:6 undriven.
  assert_osc_oe_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mode |-> (pin_oe[7:6] == 2'b00));

  // R5: strap masks bits 7:6 of the port, latch and direction reads.
  assert_osc_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_mode && bus_addr < ADDR_W'(3)) |-> (bus_rdata[7:6] == 2'b00));

  // R6: analog-select reads keep bits 7:5 clear.
  assert_ana_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(3)) |-> (bus_rdata[7:5] == 3'b000));

  // R9: unused addresses read as zero.
  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= ADDR_W'(4)) |-> (bus_rdata == 8'h00));

endmodule

bind gpio_port8 gpio_port8_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .osc_mode  (osc_mode),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out)
);

// File: tb/tb_gpio_port8.sv
module tb_gpio_port8;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       osc_mode;
  logic [7:0] pin_in;
  logic [7:0] pin_oe;
  logic [7:0] pin_out;

  int applied = 0;
  int miscmp  = 0;

  gpio_port8 dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .osc_mode  (osc_mode),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {req, wr, waddr, wdata, pins, osc, raddr, exp_rd, exp_oe, exp_out}
  typedef logic [51:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {4'd8,  1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 3'd0, 8'hD0, 8'h00, 8'h00}, // R8 analog pins masked
    {4'd6,  1'b1, 3'd3, 8'h00, 8'hA5, 1'b0, 3'd3, 8'h00, 8'h00, 8'h00}, // R6 clear analog
    {4'd2,  1'b0, 3'd0, 8'h00, 8'hA5, 1'b0, 3'd0, 8'hA5, 8'h00, 8'h00}, // R2 pins visible
    {4'd1,  1'b1, 3'd2, 8'hF0, 8'h3C, 1'b0, 3'd2, 8'hF0, 8'h0F, 8'h00}, // R1 low nibble out
    {4'd3,  1'b1, 3'd0, 8'h5A, 8'h3C, 1'b0, 3'd0, 8'h3C, 8'h0F, 8'h5A}, // R3 port write, pin read
    {4'd4,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 3'd1, 8'h5A, 8'h0F, 8'h5A}, // R4 latch read
    {4'd4,  1'b1, 3'd1, 8'hC3, 8'hFF, 1'b0, 3'd1, 8'hC3, 8'h0F, 8'hC3}, // R4 latch write
    {4'd5,  1'b1, 3'd2, 8'h00, 8'hFF, 1'b1, 3'd2, 8'h00, 8'h3F, 8'hC3}, // R5 dir masked
    {4'd5,  1'b0, 3'd0, 8'h00, 8'hFF, 1'b1, 3'd1, 8'h03, 8'h3F, 8'hC3}, // R5 latch masked
    {4'd5,  1'b0, 3'd0, 8'h00, 8'hFF, 1'b1, 3'd0, 8'h3F, 8'h3F, 8'hC3}, // R5 port masked
    {4'd6,  1'b1, 3'd3, 8'hFF, 8'hFF, 1'b0, 3'd3, 8'h1F, 8'hFF, 8'hC3}, // R6 upper bits ignored
    {4'd7,  1'b0, 3'd0, 8'h00, 8'hFF, 1'b0, 3'd0, 8'hD0, 8'hFF, 8'hC3}, // R7 analog pins still driven
    {4'd9,  1'b1, 3'd5, 8'h12, 8'h00, 1'b0, 3'd5, 8'h00, 8'hFF, 8'hC3}, // R9 unused reads zero
    {4'd9,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 3'd1, 8'hC3, 8'hFF, 8'hC3}, // R9 latch untouched
    {4'd9,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 3'd2, 8'h00, 8'hFF, 8'hC3}, // R9 dir untouched
    {4'd5,  1'b1, 3'd2, 8'h80, 8'h00, 1'b0, 3'd2, 8'h80, 8'h7F, 8'hC3}, // R5 pin 7 input
    {4'd5,  1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 3'd2, 8'h00, 8'h3F, 8'hC3}, // R5 strap hides bit 7
    {4'd5,  1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 3'd2, 8'h80, 8'h7F, 8'hC3}  // R5 stored bit returns
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    string req;
    req = $sformatf("R%0d", v[51:48]);
    @(negedge clk);
    pin_in    = v[35:28];
    osc_mode  = v[27];
    bus_addr  = v[46:44];
    bus_we    = v[47];
    bus_wdata = v[43:36];
    @(posedge clk);
    @(negedge clk);
    bus_we   = 1'b0;
    bus_addr = v[26:24];
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(req, "rdata", bus_rdata, v[23:16]);
    check(req, "oe",    pin_oe,    v[15:8]);
    check(req, "out",   pin_out,   v[7:0]);
  endtask

  task automatic peek(input string req, input logic [2:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    check(req, $sformatf("addr%0d", a), bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    osc_mode = 1'b0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);

    // R8: reset values
    peek("R8", 3'd1, 8'h00);
    peek("R8", 3'd2, 8'hFF);
    peek("R8", 3'd3, 8'h1F);
    check("R8", "oe", pin_oe, 8'h00);
    check("R8", "out", pin_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i]);
    end

    // R10: write data present without enable changes nothing
    @(negedge clk);
    bus_addr = 3'd1; bus_wdata = 8'hFF; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", "rdata", bus_rdata, 8'hC3);
    check("R10", "out", pin_out, 8'hC3);
    // R10: read data follows the address without a clock
    peek("R10", 3'd2, 8'h80);

    // R2: two-edge synchronizer latency
    run_vec({4'd2, 1'b1, 3'd3, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 8'h7F, 8'hC3});
    pin_in = 8'h81;
    @(posedge clk);
    @(negedge clk);
    check("R2", "after one edge", bus_rdata, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R2", "after two edges", bus_rdata, 8'h81);

    // R8: asynchronous reset mid-run
    pin_in = 8'hFF;
    rst_n = 1'b0;
    #1;
    check("R8", "oe in reset", pin_oe, 8'h00);
    check("R8", "out in reset", pin_out, 8'h00);
    peek("R8", 3'd2, 8'hFF);
    peek("R8", 3'd3, 8'h1F);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    peek("R8", 3'd0, 8'hD0);

    finish_run();
  end

endmodule